// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

This block sits between an instruction queue and two in-order execution pipelines, called top and bottom. It looks at the oldest two queue entries, the head and the next, and decides each cycle how many of them to send: none, one or two. It also decides which pipeline each one goes to, and it tells the queue how many entries to drop. Only the bottom pipeline can reach data memory. Loads and stores are therefore steered into it, and the pair is reordered when that lets both instructions go. A branch or jump always leaves in the top pipeline together with its delay-slot instruction in the bottom one.

The queue-removal count is produced combinationally in the same cycle as the decision, so the queue can advance at the next edge. The two issue slots are registered and show the chosen instructions one cycle later. An empty slot carries a zero word with its valid bit low.

Top module: `iss_pair_top`

## Requirements
- R1: After reset both issue slots are invalid with zero instruction words, and the pop count is 0 while the head entry is invalid.
- R2: While stall is high, or while the head entry is invalid, the pop count is 0 and both slots are invalid on the following cycle.
- R3: Two valid, independent, non-memory, non-control entries issue together: the head goes to top, the next goes to bottom, and the pop count is 2.
- R4: An instruction whose opcode bit 31 is 1 is a memory operation (load when bit 29 is 0, store when bit 29 is 1). A memory operation never appears in the top slot, and a memory operation issued alone goes to the bottom slot.
- R5: When both entries are memory operations and R7 does not apply, only the head issues (bottom slot) and the pop count is 1.
- R6: When a memory head is followed by an independent non-memory, non-control entry, the pair is swapped: the next goes to top, the head to bottom, and the pop count is 2.
- R7: When two loads write the same nonzero register (bits 20:16) and the second load's base register (bits 25:21) differs from it, only the second load issues (bottom slot) and the pop count is 2.
- R8: Control instructions are opcodes 1 to 7, and opcode 0 with function code 8 or 9. A control head with a valid next entry issues as head in top and next in bottom with pop count 2. A control head without a valid next entry waits with pop count 0.
- R9: When the next entry is a control instruction and the head is not, only the head issues and the pop count is 1.
- R10: A dependency is the head's destination being read or written by the next entry. Destination is rd (15:11) for opcode 0, rt (20:16) for opcodes 8 to 15 and loads, and register 31 for opcode 3. Sources are rs for all but opcodes 2 and 3, and rt for opcodes 0, 4, 5 and stores. Register 0 is never a dependency. When a dependency exists, only the head issues and the pop count is 1.
- R11: When the next entry is invalid and the head is not a control instruction, only the head issues and the pop count is 1.
- R12: The issue slots reflect the decision made in the previous cycle, while the pop count reflects the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Issue nothing this cycle |
| headInstr | input | 32 | Oldest queue entry |
| headValid | input | 1 | Head entry present |
| nextInstr | input | 32 | Second-oldest queue entry |
| nextValid | input | 1 | Next entry present |
| topInstr | output | 32 | Instruction issued to the top pipeline |
| topValid | output | 1 | Top slot holds an instruction |
| botInstr | output | 32 | Instruction issued to the bottom pipeline |
| botValid | output | 1 | Bottom slot holds an instruction |
| popCount | output | 2 | Entries the queue removes this cycle |

## Verification
The checker assumes the queue never places a control instruction in the delay slot of another. Under that assumption no control word can land in the bottom slot. It also assumes that the next entry is only valid when the head is valid. The stimulus draws random pairs from a small register pool so that hazards are frequent. Whenever it would place two control instructions back to back, it replaces the second with an add, and it never raises nextValid without headValid.

// File: rtl/iss_pair_pkg.sv
package iss_pair_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int POP_W   = 2;

  typedef struct packed {
    logic             isMem;
    logic             isLoad;
    logic             isCtl;
    logic [REG_W-1:0] dest;
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
  } instInfo_t;

  typedef enum logic [1:0] {SEL_NONE, SEL_HEAD, SEL_NEXT} slotSel_e;

  typedef struct packed {
    slotSel_e         topSel;
    slotSel_e         botSel;
    logic [POP_W-1:0] pop;
  } issueStrobe_t;
endpackage

// File: rtl/iss_decode.sv
module iss_decode
  import iss_pair_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output instInfo_t          info
);
  logic [5:0] opc;
  logic [5:0] fnc;
  logic [REG_W-1:0] rsF, rtF, rdF;

  assign opc = instr[31:26];
  assign fnc = instr[5:0];
  assign rsF = instr[25:21];
  assign rtF = instr[20:16];
  assign rdF = instr[15:11];

  always_comb begin
    info        = '0;
    info.isMem  = opc[5];
    info.isLoad = opc[5] & ~opc[3];
    info.isCtl  = ((opc >= 6'd1) && (opc <= 6'd7)) ||
                  ((opc == 6'd0) && (fnc[5:1] == 5'b00100));
    if (opc == 6'd0)                     info.dest = rdF;
    else if (opc[5:3] == 3'b001)         info.dest = rtF;
    else if (opc[5] && !opc[3])          info.dest = rtF;
    else if (opc == 6'd3)                info.dest = '1;
    if ((opc != 6'd2) && (opc != 6'd3))  info.src1 = rsF;
    if ((opc == 6'd0) || (opc == 6'd4) || (opc == 6'd5) || (opc[5] && opc[3]))
      info.src2 = rtF;
  end
endmodule

// File: rtl/iss_pair_ctrl.sv
module iss_pair_ctrl
  import iss_pair_pkg::*;
(
  input  logic         stall,
  input  logic         headValid,
  input  logic         nextValid,
  input  instInfo_t    headInfo,
  input  instInfo_t    nextInfo,
  output issueStrobe_t strb
);
  logic depRaw, depWaw, collapse;

  always_comb begin
    depRaw = (headInfo.dest != '0) &&
             ((headInfo.dest == nextInfo.src1) || (headInfo.dest == nextInfo.src2));
    depWaw = (headInfo.dest != '0) && (headInfo.dest == nextInfo.dest);
    collapse = headInfo.isLoad && nextInfo.isLoad && (headInfo.dest != '0) &&
               (headInfo.dest == nextInfo.dest) && (nextInfo.src1 != headInfo.dest);
  end

  always_comb begin
    strb = '{topSel: SEL_NONE, botSel: SEL_NONE, pop: '0};
    if (stall || !headValid) begin
      strb.pop = '0;
    end else if (headInfo.isCtl) begin
      if (nextValid) begin
        strb.topSel = SEL_HEAD;
        strb.botSel = SEL_NEXT;
        strb.pop    = 2'd2;
      end
    end else if (nextValid && collapse) begin
      strb.botSel = SEL_NEXT;
      strb.pop    = 2'd2;
    end else if (!nextValid || nextInfo.isCtl || depRaw || depWaw ||
                 (headInfo.isMem && nextInfo.isMem)) begin
      if (headInfo.isMem) strb.botSel = SEL_HEAD;
      else                strb.topSel = SEL_HEAD;
      strb.pop = 2'd1;
    end else if (headInfo.isMem) begin
      strb.topSel = SEL_NEXT;
      strb.botSel = SEL_HEAD;
      strb.pop    = 2'd2;
    end else begin
      strb.topSel = SEL_HEAD;
      strb.botSel = SEL_NEXT;
      strb.pop    = 2'd2;
    end
  end
endmodule

// File: rtl/iss_slot_regs.sv
module iss_slot_regs
  import iss_pair_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  issueStrobe_t       strb,
  input  logic [INSTR_W-1:0] headInstr,
  input  logic [INSTR_W-1:0] nextInstr,
  output logic [INSTR_W-1:0] topInstr,
  output logic               topValid,
  output logic [INSTR_W-1:0] botInstr,
  output logic               botValid
);
  function automatic logic [INSTR_W-1:0] pickWord(slotSel_e sel,
      logic [INSTR_W-1:0] h, logic [INSTR_W-1:0] n);
    case (sel)
      SEL_HEAD: return h;
      SEL_NEXT: return n;
      default:  return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topInstr <= '0;
      topValid <= 1'b0;
      botInstr <= '0;
      botValid <= 1'b0;
    end else begin
      topInstr <= pickWord(strb.topSel, headInstr, nextInstr);
      topValid <= (strb.topSel != SEL_NONE);
      botInstr <= pickWord(strb.botSel, headInstr, nextInstr);
      botValid <= (strb.botSel != SEL_NONE);
    end
  end
endmodule

// File: rtl/iss_pair_top.sv
module iss_pair_top
  import iss_pair_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  logic [INSTR_W-1:0] headInstr,
  input  logic               headValid,
  input  logic [INSTR_W-1:0] nextInstr,
  input  logic               nextValid,
  output logic [INSTR_W-1:0] topInstr,
  output logic               topValid,
  output logic [INSTR_W-1:0] botInstr,
  output logic               botValid,
  output logic [POP_W-1:0]   popCount
);
  instInfo_t    headInfo, nextInfo;
  issueStrobe_t strb;

  iss_decode u_decHead (.instr(headInstr), .info(headInfo));
  iss_decode u_decNext (.instr(nextInstr), .info(nextInfo));

  iss_pair_ctrl u_ctrl (
    .stall(stall), .headValid(headValid), .nextValid(nextValid),
    .headInfo(headInfo), .nextInfo(nextInfo), .strb(strb)
  );

  iss_slot_regs u_slots (
    .clk(clk), .rstN(rstN), .strb(strb),
    .headInstr(headInstr), .nextInstr(nextInstr),
    .topInstr(topInstr), .topValid(topValid),
    .botInstr(botInstr), .botValid(botValid)
  );

  assign popCount = strb.pop;
endmodule

// File: rtl/iss_pair_chk.sv
module iss_pair_chk
  import iss_pair_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               stall,
  input logic               headValid,
  input logic [INSTR_W-1:0] topInstr,
  input logic               topValid,
  input logic [INSTR_W-1:0] botInstr,
  input logic               botValid,
  input logic [POP_W-1:0]   popCount
);
  function automatic logic ctlWord(logic [INSTR_W-1:0] w);
    return ((w[31:26] >= 6'd1) && (w[31:26] <= 6'd7)) ||
           ((w[31:26] == 6'd0) && (w[5:1] == 5'b00100));
  endfunction

  // R2
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stall || !headValid) |-> (popCount == '0));
  // R2
  stall_slots_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (!topValid && !botValid));
  // R4
  mem_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    topValid |-> !topInstr[31]);
  // R8
  ctl_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (topValid && ctlWord(topInstr)) |-> botValid);
  // R8
  ctl_bot_chk: assert property (@(posedge clk) disable iff (!rstN)
    botValid |-> !ctlWord(botInstr));
  // R12
  pop_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popCount != '0) |=> (topValid || botValid));
  // R12
  pop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popCount == '0) |=> (!topValid && !botValid));
  // R3
  pop_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    popCount <= 2'd2);
endmodule

bind iss_pair_top iss_pair_chk u_chk (
  .clk(clk), .rstN(rstN), .stall(stall), .headValid(headValid),
  .topInstr(topInstr), .topValid(topValid), .botInstr(botInstr),
  .botValid(botValid), .popCount(popCount)
);

// File: tb/iss_pair_top_tb.sv
module iss_pair_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] headInstr = '0, nextInstr = '0;
  logic        headValid = 1'b0, nextValid = 1'b0;
  logic [31:0] topInstr, botInstr;
  logic        topValid, botValid;
  logic [1:0]  popCount;
  int          nChecks = 0, nFails = 0;
  bit          doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iss_pair_top u_dut (
    .clk(clk), .rstN(rstN), .stall(stall),
    .headInstr(headInstr), .headValid(headValid),
    .nextInstr(nextInstr), .nextValid(nextValid),
    .topInstr(topInstr), .topValid(topValid),
    .botInstr(botInstr), .botValid(botValid), .popCount(popCount)
  );

  function automatic logic [31:0] mkR(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] mkI(int op, int rs, int rt);
    return {6'(op), 5'(rs), 5'(rt), 16'h0004};
  endfunction

  function automatic bit isMemW(logic [31:0] w); return w[31:26] >= 6'd32; endfunction
  function automatic bit isLdW(logic [31:0] w);
    return (w[31:26] >= 6'd32) && (w[31:26] < 6'd40);
  endfunction
  function automatic bit isCtlW(logic [31:0] w);
    int op = int'(w[31:26]);
    int fn = int'(w[5:0]);
    return (op >= 1 && op <= 7) || (op == 0 && (fn == 8 || fn == 9));
  endfunction
  function automatic int dstOf(logic [31:0] w);
    int op = int'(w[31:26]);
    if (op == 0) return int'(w[15:11]);
    if ((op >= 8 && op <= 15) || (op >= 32 && op < 40)) return int'(w[20:16]);
    if (op == 3) return 31;
    return 0;
  endfunction
  function automatic bit readsReg(logic [31:0] w, int r);
    int op = int'(w[31:26]);
    bit usesRs = (op != 2) && (op != 3);
    bit usesRt = (op == 0) || (op == 4) || (op == 5) || (op >= 40);
    if (r == 0) return 0;
    return (usesRs && int'(w[25:21]) == r) || (usesRt && int'(w[20:16]) == r);
  endfunction

  // Reference: t/b = 0 none, 1 head, 2 next; p = pop; tag = requirement
  task automatic refModel(output int t, output int b, output int p, output string tag);
    int d = dstOf(headInstr);
    t = 0; b = 0; p = 0; tag = "R2";
    if (stall || !headValid) return;
    if (isCtlW(headInstr)) begin
      tag = "R8";
      if (nextValid) begin t = 1; b = 2; p = 2; end
      return;
    end
    if (!nextValid)                 tag = "R11";
    else if (isLdW(headInstr) && isLdW(nextInstr) && d != 0 &&
             dstOf(nextInstr) == d && int'(nextInstr[25:21]) != d) begin
      tag = "R7"; b = 2; p = 2; return;
    end
    else if (isCtlW(nextInstr))     tag = "R9";
    else if (d != 0 && (readsReg(nextInstr, d) || dstOf(nextInstr) == d)) tag = "R10";
    else if (isMemW(headInstr) && isMemW(nextInstr)) tag = "R5";
    else if (isMemW(headInstr)) begin tag = "R6"; t = 2; b = 1; p = 2; return; end
    else begin tag = "R3"; t = 1; b = 2; p = 2; return; end
    p = 1;
    if (isMemW(headInstr)) begin b = 1; if (tag == "R11") tag = "R4"; end
    else t = 1;
  endtask

  task automatic chk(string tag, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic st, logic [31:0] h, logic hv, logic [31:0] n, logic nv);
    int t, b, p;
    string tag;
    logic [31:0] et, eb;
    @(negedge clk);
    stall = st; headInstr = h; headValid = hv; nextInstr = n; nextValid = nv;
    #1;
    refModel(t, b, p, tag);
    chk(tag, "pop", popCount, p);
    et = (t == 1) ? h : (t == 2) ? n : 32'h0;
    eb = (b == 1) ? h : (b == 2) ? n : 32'h0;
    @(posedge clk); #1;
    // R12: slots follow the previous cycle's decision
    chk(tag, "topValid", topValid, t != 0);
    chk(tag, "topInstr", topInstr, et);
    chk(tag, "botValid", botValid, b != 0);
    chk(tag, "botInstr", botInstr, eb);
  endtask

  function automatic logic [31:0] randInstr();
    int k  = $urandom_range(0, 8);
    int r1 = $urandom_range(0, 3), r2 = $urandom_range(0, 3), r3 = $urandom_range(0, 3);
    case (k)
      0, 1: return mkR(r1, r2, r3, 33);
      2:    return mkI(9, r1, r2);
      3:    return mkI(35, r1, r2);
      4:    return mkI(43, r1, r2);
      5:    return mkI(4, r1, r2);
      6:    return {6'd2, 26'h40};
      7:    return mkI(32, r1, r2);
      default: return ($urandom_range(0, 1) != 0) ? {6'd3, 26'h80} : mkR(31, 0, 0, 8);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "topValid", topValid, 0);
    chk("R1", "botValid", botValid, 0);
    chk("R1", "topInstr", topInstr, 0);
    chk("R1", "pop", popCount, 0);
    @(negedge clk); rstN = 1'b1;

    step(0, mkR(1, 2, 3, 33), 1, mkR(4, 5, 6, 33), 1);       // R3
    step(1, mkR(1, 2, 3, 33), 1, mkR(4, 5, 6, 33), 1);       // R2 stall
    step(0, mkR(1, 2, 3, 33), 0, mkR(4, 5, 6, 33), 0);       // R2 empty
    step(0, mkI(35, 1, 2), 1, mkR(4, 5, 6, 33), 1);          // R6 swap
    step(0, mkR(4, 5, 6, 33), 1, mkI(43, 1, 2), 1);          // R3 mem already bottom
    step(0, mkI(35, 1, 2), 1, mkI(43, 3, 4), 1);             // R5
    step(0, mkI(35, 1, 7), 1, mkI(35, 2, 7), 1);             // R7 collapse
    step(0, mkI(35, 1, 7), 1, mkI(35, 7, 7), 1);             // R10 base uses dest
    step(0, mkI(35, 1, 0), 1, mkI(35, 2, 0), 1);             // R5 r0 dest
    step(0, mkI(4, 1, 2), 1, mkR(1, 2, 3, 33), 1);           // R8 branch + slot
    step(0, mkI(4, 1, 2), 1, 32'h0, 0);                      // R8 wait for slot
    step(0, mkR(1, 2, 3, 33), 1, {6'd2, 26'h40}, 1);         // R9
    step(0, mkR(1, 2, 3, 33), 1, mkR(3, 5, 6, 33), 1);       // R10 RAW rs
    step(0, mkI(9, 1, 5), 1, mkI(43, 2, 5), 1);              // R10 RAW store rt
    step(0, mkR(1, 2, 3, 33), 1, mkI(9, 4, 3), 1);           // R10 WAW
    step(0, mkR(1, 2, 0, 33), 1, mkR(0, 0, 6, 33), 1);       // R10 r0 ignored
    step(0, mkR(1, 2, 3, 33), 1, 32'h0, 0);                  // R11
    step(0, mkI(43, 1, 2), 1, 32'h0, 0);                     // R4 lone store

    for (int i = 0; i < 600; i++) begin
      logic [31:0] h = randInstr();
      logic [31:0] n = randInstr();
      logic hv = ($urandom_range(0, 9) != 0);
      logic nv = hv && ($urandom_range(0, 5) != 0);
      if (isCtlW(h) && isCtlW(n)) n = mkR(1, 2, 3, 33);
      step($urandom_range(0, 7) == 0, h, hv, n, nv);
    end

    doneFlag = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule